// File: doc/BRIEF.md
# Priority Interrupt Arbiter With Nesting

This block decides which of 32 interrupt sources the processor should service next. Each source raises a one-cycle request pulse. The pulse is captured in a pending flag, so it does not matter how long the peripheral's own status flag stays set. Software gives every source a priority and an enable through a small write port. The arbiter picks the most urgent enabled pending source and raises a take request only when that source is strictly more urgent than the handler already running. That rule is what lets interrupts nest.

The processor model answers a take request with an acknowledge strobe. On acknowledge, the arbiter clears the chosen source's pending flag and pushes the source's level onto a four-entry stack of active levels. The processor model raises a completion strobe when a handler finishes, and the arbiter pops the stack. If a pending request outranks the level that is exposed after the pop, the arbiter flags a tail-chain condition. The processor can then enter the next handler directly, without first returning to the interrupted context. Fetching vectors and saving processor state are left to the processor model.

Top module: `prio_irq_arbiter`

## Requirements
- R1: A request pulse always sets that source's pending flag, even when the source is disabled. A disabled source is never selected. Enabling it later lets its stored request be taken.
- R2: Only bits [7:6] of the 8-bit priority written for a source are stored. Reading the field back, one cycle after `rd_idx` is presented, returns those two bits with bits [5:0] zero.
- R3: A smaller stored level is more urgent. The arbiter selects the enabled pending source with the smallest level.
- R4: When several enabled pending sources share the smallest level, the one with the lowest source number is selected.
- R5: `take_irq` is raised with `sel_id` only when the stack is empty, or when the selected level is strictly smaller than the level on top of the stack. A request at an equal or larger level waits.
- R6: An acknowledge given while `take_irq` is high clears the pending flag of `sel_id` and pushes its level, so `nest_depth` grows by one. `take_irq` is low in the cycle after the acknowledge. An acknowledge given while `take_irq` is low, or in the same cycle as `done`, is ignored.
- R7: A pulse from a source whose handler is active sets its pending flag again, and that source is taken again once it outranks the active level.
- R8: `done` pops one level from the stack. A `done` with an empty stack is ignored.
- R9: In the cycle after a `done` that pops a level, `tail_chain` is high when an enabled pending source is strictly more urgent than the level left on top. If the stack became empty, any enabled pending source qualifies. `sel_id` then names that source.
- R10: `nest_depth` never exceeds 4. With all four levels active, further requests are not taken.
- R11: After reset, no flag is pending, all sources are disabled at level 0, `nest_depth` is 0, and `take_irq`, `tail_chain`, `sel_id` and `rd_prio` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for one source's priority and enable |
| cfg_idx | input | 5 | Source number written |
| cfg_prio | input | 8 | Priority field; only bits [7:6] are kept |
| cfg_en | input | 1 | Enable written for the source |
| rd_idx | input | 5 | Source number whose priority field is read back |
| rd_prio | output | 8 | Registered read-back of the priority field |
| req_pulse | input | 32 | One bit per source; a high cycle is a request |
| ack | input | 1 | Processor accepts the request shown by `take_irq` |
| done | input | 1 | Processor finished the current handler |
| take_irq | output | 1 | Selected source should preempt now |
| sel_id | output | 5 | Source number selected by arbitration |
| tail_chain | output | 1 | Completion found a qualifying pending request |
| nest_depth | output | 3 | Number of levels currently active |

## Verification
A stack entry that is lost or stale shows up at the ports as a wrong `nest_depth` one cycle after the acknowledge or completion that caused it. It also corrupts the preemption decision, so `take_irq` rises for an equal-level request or stays low for a more urgent one on the very next evaluation. A pending flag that is dropped or stuck shows up as a source that is never selected after it is enabled, or as one that is selected twice. The comparison against the reference model catches either case within two cycles. Tie-breaking and tail-chain faults are exposed by firing several sources in one cycle, and by completing handlers while requests of equal and of greater urgency wait.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned DEF_NUM_SRC   = 32;
  localparam int unsigned DEF_PRIO_BITS = 2;
  localparam int unsigned DEF_FIELD_W   = 8;
endpackage

// File: rtl/arb_prio_regs.sv
module arb_prio_regs #(
  parameter int unsigned NUM_SRC   = 32,
  parameter int unsigned LVL_W     = 2,
  parameter int unsigned FIELD_W   = 8,
  localparam int unsigned ID_W     = $clog2(NUM_SRC)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [ID_W-1:0]                 wr_idx,
  input  logic [FIELD_W-1:0]              wr_field,
  input  logic                            wr_en,
  input  logic [ID_W-1:0]                 rd_idx,
  output logic [FIELD_W-1:0]              rd_field,
  output logic [NUM_SRC-1:0][LVL_W-1:0]   lvl_vec,
  output logic [NUM_SRC-1:0]              en_vec
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_vec  <= '0;
      en_vec   <= '0;
      rd_field <= '0;
    end else begin
      if (we) begin
        lvl_vec[wr_idx] <= wr_field[FIELD_W-1 -: LVL_W];
        en_vec[wr_idx]  <= wr_en;
      end
      rd_field <= {lvl_vec[rd_idx], {(FIELD_W-LVL_W){1'b0}}};
    end
  end
endmodule

// File: rtl/arb_pending.sv
module arb_pending #(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_pulse,
  input  logic               clr_en,
  input  logic [ID_W-1:0]    clr_id,
  output logic [NUM_SRC-1:0] pend
);
  logic [NUM_SRC-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    if (clr_en) clr_mask[clr_id] = 1'b1;
  end

  // a new pulse wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr_mask) | req_pulse;
  end

  assert_pulse_latched_R1: assert property (@(posedge clk) disable iff (rst)
    (req_pulse != '0) |=> ((pend & $past(req_pulse)) == $past(req_pulse)));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !req_pulse[clr_id]) |=> !pend[$past(clr_id)]);
endmodule

// File: rtl/arb_select.sv
module arb_select #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned LVL_W   = 2,
  localparam int unsigned ID_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]            elig,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_vec,
  output logic                          best_v,
  output logic [ID_W-1:0]               best_id,
  output logic [LVL_W-1:0]              best_lvl
);
  // ascending scan with strict compare keeps the lowest number on ties
  always_comb begin
    best_v   = 1'b0;
    best_id  = '0;
    best_lvl = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!best_v || lvl_vec[i] < best_lvl)) begin
        best_v   = 1'b1;
        best_id  = ID_W'(i);
        best_lvl = lvl_vec[i];
      end
    end
  end
endmodule

// File: rtl/arb_level_stack.sv
module arb_level_stack #(
  parameter int unsigned LVL_W  = 2,
  localparam int unsigned DEPTH = 2 ** LVL_W,
  localparam int unsigned IDX_W = (LVL_W < 1) ? 1 : LVL_W,
  localparam int unsigned SP_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop,
  output logic [SP_W-1:0]  depth,
  output logic [LVL_W-1:0] top_lvl,
  output logic [LVL_W-1:0] below_lvl
);
  logic [LVL_W-1:0] stk [DEPTH];

  assign top_lvl   = (depth != '0) ? stk[IDX_W'(depth - SP_W'(1))] : '0;
  assign below_lvl = (depth > SP_W'(1)) ? stk[IDX_W'(depth - SP_W'(2))] : '0;

  always_ff @(posedge clk) begin
    if (push) stk[IDX_W'(depth)] <= push_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst)       depth <= '0;
    else if (push) depth <= depth + SP_W'(1);
    else if (pop)  depth <= depth - SP_W'(1);
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    push |-> (depth < SP_W'(DEPTH)));

  assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (rst)
    pop |-> (depth != '0));

  assert_strict_nesting_R5: assert property (@(posedge clk) disable iff (rst)
    (push && depth != '0) |-> (push_lvl < top_lvl));
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter #(
  parameter int unsigned NUM_SRC   = arb_pkg::DEF_NUM_SRC,
  parameter int unsigned PRIO_BITS = arb_pkg::DEF_PRIO_BITS,
  parameter int unsigned FIELD_W   = arb_pkg::DEF_FIELD_W,
  localparam int unsigned ID_W     = $clog2(NUM_SRC),
  localparam int unsigned SP_W     = $clog2((2 ** PRIO_BITS) + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [ID_W-1:0]    cfg_idx,
  input  logic [FIELD_W-1:0] cfg_prio,
  input  logic               cfg_en,
  input  logic [ID_W-1:0]    rd_idx,
  output logic [FIELD_W-1:0] rd_prio,
  input  logic [NUM_SRC-1:0] req_pulse,
  input  logic               ack,
  input  logic               done,
  output logic               take_irq,
  output logic [ID_W-1:0]    sel_id,
  output logic               tail_chain,
  output logic [SP_W-1:0]    nest_depth
);
  logic [NUM_SRC-1:0][PRIO_BITS-1:0] lvl_vec;
  logic [NUM_SRC-1:0]                en_vec, pend;
  logic                              best_v;
  logic [ID_W-1:0]                   best_id;
  logic [PRIO_BITS-1:0]              best_lvl, top_lvl, below_lvl, sel_lvl_q;
  logic                              ack_ok, done_ok, can_take, outranks_below;

  arb_prio_regs #(.NUM_SRC(NUM_SRC), .LVL_W(PRIO_BITS), .FIELD_W(FIELD_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .wr_idx(cfg_idx), .wr_field(cfg_prio),
    .wr_en(cfg_en), .rd_idx(rd_idx), .rd_field(rd_prio),
    .lvl_vec(lvl_vec), .en_vec(en_vec));

  arb_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst(rst), .req_pulse(req_pulse),
    .clr_en(ack_ok), .clr_id(sel_id), .pend(pend));

  arb_select #(.NUM_SRC(NUM_SRC), .LVL_W(PRIO_BITS)) u_sel (
    .elig(pend & en_vec), .lvl_vec(lvl_vec),
    .best_v(best_v), .best_id(best_id), .best_lvl(best_lvl));

  arb_level_stack #(.LVL_W(PRIO_BITS)) u_stack (
    .clk(clk), .rst(rst), .push(ack_ok), .push_lvl(sel_lvl_q), .pop(done_ok),
    .depth(nest_depth), .top_lvl(top_lvl), .below_lvl(below_lvl));

  assign ack_ok         = ack && take_irq && !done;
  assign done_ok        = done && (nest_depth != '0);
  assign can_take       = best_v && ((nest_depth == '0) || (best_lvl < top_lvl));
  assign outranks_below = (nest_depth < SP_W'(2)) || (best_lvl < below_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      take_irq   <= 1'b0;
      tail_chain <= 1'b0;
      sel_id     <= '0;
      sel_lvl_q  <= '0;
    end else begin
      take_irq   <= can_take && !ack_ok && !done;
      tail_chain <= done_ok && best_v && outranks_below;
      if (best_v) begin
        sel_id    <= best_id;
        sel_lvl_q <= best_lvl;
      end
    end
  end

  assert_take_drops_R6: assert property (@(posedge clk) disable iff (rst)
    (take_irq && ack) |=> !take_irq);

  assert_tail_after_done_R9: assert property (@(posedge clk) disable iff (rst)
    tail_chain |-> $past(done));

  assert_take_outranks_R5: assert property (@(posedge clk) disable iff (rst)
    (take_irq && nest_depth != '0) |-> (sel_lvl_q < top_lvl));

  assert_depth_bound_R10: assert property (@(posedge clk) disable iff (rst)
    nest_depth <= SP_W'(2 ** PRIO_BITS));
endmodule

// File: tb/sim_prio_irq_arbiter.sv
module sim_prio_irq_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic clk = 0, rst = 1;
  logic cfg_we = 0, cfg_en = 0, ack = 0, done = 0;
  logic [4:0] cfg_idx = 0, rd_idx = 0, sel_id;
  logic [7:0] cfg_prio = 0, rd_prio;
  logic [N-1:0] req_pulse = '0;
  logic take_irq, tail_chain;
  logic [2:0] nest_depth;

  int checks = 0, fails = 0, cyc = 0;

  // reference model state
  bit m_pend[N], m_en[N];
  int m_lvl[N];
  int m_stk[$];
  bit m_take, m_tail;
  int m_sel, m_sel_lvl, m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_arbiter u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_prio(cfg_prio),
    .cfg_en(cfg_en), .rd_idx(rd_idx), .rd_prio(rd_prio), .req_pulse(req_pulse),
    .ack(ack), .done(done), .take_irq(take_irq), .sel_id(sel_id),
    .tail_chain(tail_chain), .nest_depth(nest_depth));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(int idx, int prio, bit en);
    cfg_we = 1; cfg_idx = 5'(idx); cfg_prio = 8'(prio); cfg_en = en;
    step(1);
    cfg_we = 0;
  endtask

  task automatic fire(logic [N-1:0] m);
    req_pulse = m; step(1); req_pulse = '0;
  endtask

  task automatic do_ack(); ack = 1; step(1); ack = 0; endtask
  task automatic do_done(); done = 1; step(1); done = 0; endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      foreach (m_pend[i]) begin m_pend[i] = 0; m_en[i] = 0; m_lvl[i] = 0; end
      m_stk.delete();
      m_take = 0; m_tail = 0; m_sel = 0; m_sel_lvl = 0; m_rd = 0;
    end else begin
      bit bv, d_ok, a_ok, nt, nl;
      int bi, bp, sz;
      bv = 0; bi = 0; bp = 4;
      for (int i = 0; i < N; i++)
        if (m_pend[i] && m_en[i] && (!bv || m_lvl[i] < bp)) begin bv = 1; bi = i; bp = m_lvl[i]; end
      sz = m_stk.size();
      d_ok = done && sz > 0;
      a_ok = ack && m_take && !done;
      nt = bv && (sz == 0 || bp < m_stk[sz-1]) && !a_ok && !done;
      nl = d_ok && bv && (sz < 2 || bp < m_stk[sz-2]);
      m_rd = m_lvl[rd_idx] * 64;
      if (a_ok) begin m_pend[m_sel] = 0; m_stk.push_back(m_sel_lvl); end
      for (int i = 0; i < N; i++) if (req_pulse[i]) m_pend[i] = 1;
      if (d_ok) void'(m_stk.pop_back());
      if (cfg_we) begin m_lvl[cfg_idx] = int'(cfg_prio[7:6]); m_en[cfg_idx] = cfg_en; end
      if (bv) begin m_sel = bi; m_sel_lvl = bp; end
      m_take = nt; m_tail = nl;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R5 take_irq vs model", int'(take_irq), int'(m_take));
      chk("R9 tail_chain vs model", int'(tail_chain), int'(m_tail));
      chk("R6 nest_depth vs model", int'(nest_depth), m_stk.size());
      chk("R2 rd_prio vs model", int'(rd_prio), m_rd);
      if (take_irq || tail_chain) chk("R3 sel_id vs model", int'(sel_id), m_sel);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 0;
    step(1);
    // R11 reset state
    chk("R11 take_irq after reset", int'(take_irq), 0);
    chk("R11 nest_depth after reset", int'(nest_depth), 0);
    chk("R11 tail_chain after reset", int'(tail_chain), 0);
    chk("R11 rd_prio after reset", int'(rd_prio), 0);

    cfg(3, 8'h80, 1); cfg(9, 8'h80, 1); cfg(5, 8'hC0, 1);
    cfg(12, 8'h40, 1); cfg(20, 8'h00, 0); cfg(7, 8'hFF, 0);
    rd_idx = 7; step(1);
    chk("R2 low bits read as zero", int'(rd_prio), 8'hC0);
    rd_idx = 12; step(1);
    chk("R2 read-back level 1", int'(rd_prio), 8'h40);

    fire((32'd1 << 3) | (32'd1 << 9) | (32'd1 << 5)); step(1);
    chk("R3 take on most urgent", int'(take_irq), 1);
    chk("R4 lowest id wins tie", int'(sel_id), 3);
    do_ack();
    chk("R6 depth after ack", int'(nest_depth), 1);
    chk("R6 take low after ack", int'(take_irq), 0);
    step(1);
    chk("R5 equal level does not preempt", int'(take_irq), 0);

    fire(32'd1 << 12); step(1);
    chk("R5 more urgent preempts", int'(take_irq), 1);
    chk("R5 preempting id", int'(sel_id), 12);
    do_ack();
    chk("R6 depth two", int'(nest_depth), 2);

    fire(32'd1 << 20); step(1);
    chk("R1 disabled source not taken", int'(take_irq), 0);
    cfg(20, 8'h00, 1); step(1);
    chk("R1 stored request taken once enabled", int'(take_irq), 1);
    chk("R1 enabled id", int'(sel_id), 20);
    do_ack();

    fire(32'd1 << 12); step(1);
    chk("R7 re-pulse of active source waits", int'(take_irq), 0);
    do_done();
    chk("R8 depth after done", int'(nest_depth), 2);
    chk("R9 no tail on equal level", int'(tail_chain), 0);
    do_done();
    chk("R9 tail on more urgent pending", int'(tail_chain), 1);
    chk("R9 tail id", int'(sel_id), 12);
    step(1);
    chk("R7 re-pended source taken again", int'(take_irq), 1);
    do_ack(); do_done(); do_done();
    chk("R9 tail when stack empties", int'(tail_chain), 1);
    chk("R9 tail id on empty stack", int'(sel_id), 9);
    for (int k = 0; k < 10; k++) begin
      if (take_irq) do_ack();
      else if (nest_depth != 0) do_done();
      else step(1);
    end
    chk("R8 drained", int'(nest_depth), 0);
    do_done();
    chk("R8 done on empty stack ignored", int'(nest_depth), 0);

    cfg(0, 8'hC0, 1); cfg(1, 8'h80, 1); cfg(2, 8'h40, 1);
    cfg(4, 8'h00, 1); cfg(6, 8'h00, 1);
    for (int s = 0; s < 4; s++) begin
      fire(32'd1 << (s == 3 ? 4 : s)); step(1);
      chk("R10 nesting take", int'(take_irq), 1);
      do_ack();
    end
    chk("R10 full depth", int'(nest_depth), 4);
    fire(32'd1 << 6); step(1);
    chk("R10 no take when full", int'(take_irq), 0);
    chk("R10 depth holds", int'(nest_depth), 4);
    for (int k = 0; k < 16; k++) begin
      if (take_irq) do_ack();
      else if (nest_depth != 0) do_done();
      else step(1);
    end
    chk("R8 final drain", int'(nest_depth), 0);
    step(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule